// File: doc/BRIEF.md
# Sparse Syndrome Toggle Engine

This block refreshes the syndrome of a quasi-cyclic code decoder at the end of each iteration. It never multiplies a dense vector by a dense matrix. It reads two short lists. The first list holds the error positions found in the current iteration. The second holds the column offsets of the set bits in the first row of a circulant matrix L. For every pairing of an L offset with an error position, the engine computes one syndrome bit index as the error position minus the offset, reduced modulo the circulant size P. It then flips that bit in the word-organised syndrome memory with a read, an XOR and a write-back. Once every pair has been applied, the memory holds the old syndrome XOR e·L.

A controller loads the lists, writes the error count on `err_count` and pulses `start`. It waits for the one-cycle `done` pulse. All three memory ports use a read latency of one cycle. The generated positions also leave the block on `pos_valid`/`pos_data`/`pos_index` as an observation stream. This stream has no ready input and cannot stall the engine. Any consumer must accept one beat in every cycle in which `pos_valid` is high. The control pins `start`, `busy` and `done` are plain level and pulse signals.

Top module: `sparse_syndrome_updater`

## Requirements
- R1: After reset, `busy`, `done`, `syn_rd_en`, `syn_wr_en` and `pos_valid` are all low.
- R2: Each generated position equals (error position − L offset) mod P. A negative difference wraps by adding P, so every position lies in 0..P−1.
- R3: A position k toggles bit k mod NB of syndrome word k / NB (bit 0 is the least significant). No other bit of that word changes, and no other word changes.
- R4: Pairs are visited with the L offset index as the outer loop (0 up to L_LEN−1) and the error index as the inner loop (0 up to `err_count`−1). `pos_index` starts at 0 on every run and rises by one per emitted position.
- R5: Each pair causes exactly one syndrome read and, in the next cycle, exactly one write to the same word address. That write differs from the returned read data in exactly one bit.
- R6: Two toggles of the same position cancel, even when they target the same word in consecutive pairs. Every toggle sees the data written by the toggle before it.
- R7: With `err_count` = 0, a start performs no syndrome access and raises `done` in the cycle after the start edge.
- R8: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse. A `start` while busy is ignored and changes neither the result nor the run length.
- R9: A run with n errors takes 3·n·L_LEN cycles. `done` is high in cycle 3·n·L_LEN+1, counting the start edge as cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| err_count | input | CW | Number of valid entries in the error list |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_rd_addr | output | EIW | Error list read address |
| err_rd_data | input | PW | Error position, one cycle after the address |
| lpos_rd_addr | output | LIW | L offset list read address |
| lpos_rd_data | input | PW | L offset, one cycle after the address |
| syn_rd_en | output | 1 | Syndrome word read strobe |
| syn_wr_en | output | 1 | Syndrome word write strobe |
| syn_addr | output | WAW | Syndrome word address |
| syn_rdata | input | NB | Syndrome read data, one cycle after the strobe |
| syn_wdata | output | NB | Syndrome write data |
| pos_valid | output | 1 | Generated position beat (no back-pressure) |
| pos_data | output | PW | Generated syndrome position |
| pos_index | output | OIW | Running index of the generated position |

## Verification
A wrong pair counter or loop order would show on `pos_index`/`pos_data` at the very next beat, about three cycles after the faulty step. A broken modulo wrap would put an out-of-range or shifted value on `pos_data` in the cycle after the list data returns, and would also corrupt a memory word that is compared after `done`. A bad mask or a stale read-modify-write would leave a memory word differing from the expected syndrome by the end of the run. A miscounting sequencer would move `done` away from cycle 3·n·L_LEN+1.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CALC,
    S_WRITE,
    S_DONE
  } ssu_state_e;
endpackage

// File: rtl/ssu_pair_walker.sv
module ssu_pair_walker #(
  parameter int L_LEN   = 4,
  parameter int ERR_MAX = 8,
  parameter int CW      = 4,
  parameter int EIW     = 3,
  parameter int LIW     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           step,
  input  logic [CW-1:0]  n_err,
  output logic [EIW-1:0] err_idx,
  output logic [LIW-1:0] l_idx,
  output logic           last_pair
);
  logic [CW-1:0]  ei_q;
  logic [LIW-1:0] li_q;
  logic           last_err;

  assign last_err  = (ei_q == n_err - CW'(1));
  assign last_pair = last_err && (li_q == LIW'(L_LEN - 1));
  assign err_idx   = ei_q[EIW-1:0];
  assign l_idx     = li_q;

  // inner loop over errors, outer loop over L offsets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ei_q <= '0;
      li_q <= '0;
    end else if (clear) begin
      ei_q <= '0;
      li_q <= '0;
    end else if (step) begin
      if (last_err) begin
        ei_q <= '0;
        li_q <= li_q + LIW'(1);
      end else begin
        ei_q <= ei_q + CW'(1);
      end
    end
  end

  // R4
  err_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (ei_q < n_err));
endmodule

// File: rtl/ssu_modsub.sv
module ssu_modsub #(
  parameter int P   = 37,
  parameter int NB  = 8,
  parameter int PW  = 6,
  parameter int WAW = 3
) (
  input  logic [PW-1:0]  e_pos,
  input  logic [PW-1:0]  l_pos,
  output logic [PW-1:0]  pos,
  output logic [WAW-1:0] word_addr,
  output logic [NB-1:0]  bit_mask
);
  localparam int NB_LOG = $clog2(NB);
  localparam logic [PW:0] P_EXT = P[PW:0];

  logic [PW:0] diff;
  logic [PW:0] wrapped;

  // subtract, then add P back once if the result went negative
  always_comb begin
    diff    = {1'b0, e_pos} - {1'b0, l_pos};
    wrapped = diff[PW] ? (diff + P_EXT) : diff;
    pos     = wrapped[PW-1:0];
  end

  assign word_addr = WAW'(pos >> NB_LOG);
  assign bit_mask  = NB'(1) << pos[NB_LOG-1:0];
endmodule

// File: rtl/sparse_syndrome_updater.sv
module sparse_syndrome_updater
  import ssu_pkg::*;
#(
  parameter int P       = 1031,
  parameter int NB      = 32,
  parameter int L_LEN   = 5,
  parameter int ERR_MAX = 64,
  localparam int PW     = $clog2(P),
  localparam int WORDS  = (P + NB - 1) / NB,
  localparam int WAW    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW     = $clog2(ERR_MAX + 1),
  localparam int EIW    = (ERR_MAX > 1) ? $clog2(ERR_MAX) : 1,
  localparam int LIW    = (L_LEN > 1) ? $clog2(L_LEN) : 1,
  localparam int OIW    = $clog2(ERR_MAX * L_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   err_count,
  output logic            busy,
  output logic            done,
  output logic [EIW-1:0]  err_rd_addr,
  input  logic [PW-1:0]   err_rd_data,
  output logic [LIW-1:0]  lpos_rd_addr,
  input  logic [PW-1:0]   lpos_rd_data,
  output logic            syn_rd_en,
  output logic            syn_wr_en,
  output logic [WAW-1:0]  syn_addr,
  input  logic [NB-1:0]   syn_rdata,
  output logic [NB-1:0]   syn_wdata,
  output logic            pos_valid,
  output logic [PW-1:0]   pos_data,
  output logic [OIW-1:0]  pos_index
);
  ssu_state_e     state_q, state_d;
  logic [CW-1:0]  n_err_q;
  logic [WAW-1:0] addr_q;
  logic [NB-1:0]  mask_q;
  logic [OIW-1:0] gen_cnt_q;
  logic           pos_valid_q;
  logic [PW-1:0]  pos_q;
  logic [OIW-1:0] pos_index_q;

  logic           accept;
  logic           last_pair;
  logic [PW-1:0]  calc_pos;
  logic [WAW-1:0] calc_addr;
  logic [NB-1:0]  calc_mask;

  assign accept = (state_q == S_IDLE) && start;

  ssu_pair_walker #(
    .L_LEN(L_LEN), .ERR_MAX(ERR_MAX), .CW(CW), .EIW(EIW), .LIW(LIW)
  ) i_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .step      (state_q == S_WRITE),
    .n_err     (n_err_q),
    .err_idx   (err_rd_addr),
    .l_idx     (lpos_rd_addr),
    .last_pair (last_pair)
  );

  ssu_modsub #(
    .P(P), .NB(NB), .PW(PW), .WAW(WAW)
  ) i_modsub (
    .e_pos     (err_rd_data),
    .l_pos     (lpos_rd_data),
    .pos       (calc_pos),
    .word_addr (calc_addr),
    .bit_mask  (calc_mask)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start) state_d = (err_count == '0) ? S_DONE : S_FETCH;
      S_FETCH: state_d = S_CALC;
      S_CALC:  state_d = S_WRITE;
      S_WRITE: state_d = last_pair ? S_DONE : S_FETCH;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      n_err_q     <= '0;
      addr_q      <= '0;
      mask_q      <= '0;
      gen_cnt_q   <= '0;
      pos_valid_q <= 1'b0;
      pos_q       <= '0;
      pos_index_q <= '0;
    end else begin
      state_q     <= state_d;
      pos_valid_q <= (state_q == S_CALC);
      if (accept) begin
        n_err_q   <= err_count;
        gen_cnt_q <= '0;
      end
      if (state_q == S_CALC) begin
        addr_q      <= calc_addr;
        mask_q      <= calc_mask;
        pos_q       <= calc_pos;
        pos_index_q <= gen_cnt_q;
        gen_cnt_q   <= gen_cnt_q + OIW'(1);
      end
    end
  end

  // read issued in CALC, write-back one cycle later; the next read of any
  // word is two cycles after that write, so consecutive toggles never race
  assign syn_rd_en = (state_q == S_CALC);
  assign syn_wr_en = (state_q == S_WRITE);
  assign syn_addr  = (state_q == S_WRITE) ? addr_q : calc_addr;
  assign syn_wdata = syn_rdata ^ mask_q;

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign pos_valid = pos_valid_q;
  assign pos_data  = pos_q;
  assign pos_index = pos_index_q;

  // R5
  rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syn_wr_en |-> $past(syn_rd_en));
  // R5
  same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syn_wr_en |-> (syn_addr == $past(syn_addr)));
  // R3
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syn_wr_en |-> ($countones(syn_wdata ^ syn_rdata) == 1));
  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid |-> (pos_data < PW'(P)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!syn_rd_en && !syn_wr_en && !pos_valid));
endmodule

// File: tb/test_sparse_syndrome_updater.sv
`timescale 1ns/1ps
module test_sparse_syndrome_updater;
  localparam int P = 37, NB = 8, LL = 3, EM = 4;
  localparam int WORDS = 5;

  // table: {count(3), e3, e2, e1, e0 (6 bits each)}
  localparam logic [26:0] CASES [5] = '{
    {3'd1, 6'd0,  6'd0,  6'd0,  6'd3},
    {3'd4, 6'd25, 6'd10, 6'd0,  6'd36},
    {3'd2, 6'd0,  6'd0,  6'd7,  6'd7},
    {3'd3, 6'd0,  6'd0,  6'd20, 6'd5},
    {3'd4, 6'd4,  6'd3,  6'd2,  6'd1}
  };
  localparam int LOFF [3] = '{0, 5, 20};

  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] err_count = '0;
  logic busy, done, syn_rd_en, syn_wr_en, pos_valid;
  logic [1:0] err_rd_addr, lpos_rd_addr;
  logic [5:0] err_rd_data = '0, lpos_rd_data = '0, pos_data;
  logic [2:0] syn_addr;
  logic [7:0] syn_rdata = '0, syn_wdata;
  logic [3:0] pos_index;

  logic [5:0] err_mem [4];
  logic [5:0] lpos_mem [4];
  logic [7:0] syn_mem [WORDS];
  int checks = 0, errors = 0, wr_cnt = 0, mon_k = 0, cur_n = 0;
  bit mon_en = 0;
  int cur_e [4];
  int exp_pos [12];
  int exp_syn [WORDS];

  always #2 clk = ~clk;

  sparse_syndrome_updater #(.P(P), .NB(NB), .L_LEN(LL), .ERR_MAX(EM)) i_sparse_syndrome_updater (
    .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
    .busy(busy), .done(done),
    .err_rd_addr(err_rd_addr), .err_rd_data(err_rd_data),
    .lpos_rd_addr(lpos_rd_addr), .lpos_rd_data(lpos_rd_data),
    .syn_rd_en(syn_rd_en), .syn_wr_en(syn_wr_en), .syn_addr(syn_addr),
    .syn_rdata(syn_rdata), .syn_wdata(syn_wdata),
    .pos_valid(pos_valid), .pos_data(pos_data), .pos_index(pos_index)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory models with one-cycle read latency
  always @(posedge clk) begin
    err_rd_data  <= err_mem[err_rd_addr];
    lpos_rd_data <= lpos_mem[lpos_rd_addr];
    if (syn_rd_en) syn_rdata <= syn_mem[syn_addr];
    if (syn_wr_en) begin
      syn_mem[syn_addr] = syn_wdata;
      wr_cnt = wr_cnt + 1;
    end
  end

  // position stream monitor: R2 value, R4 order and index
  always @(negedge clk) begin
    if (mon_en && pos_valid) begin
      chk(pos_index == 4'(mon_k), "R4 index", int'(pos_index), mon_k);
      chk(pos_data == 6'(exp_pos[mon_k]), "R2 position", int'(pos_data), exp_pos[mon_k]);
      mon_k = mon_k + 1;
    end
  end

  task automatic prep(input int seed);
    int k;
    for (int i = 0; i < 4; i++) err_mem[i] = 6'(cur_e[i]);
    for (int w = 0; w < WORDS; w++) begin
      syn_mem[w] = 8'((seed * 29 + w * 53 + 7) & 255);
      exp_syn[w] = int'(syn_mem[w]);
    end
    k = 0;
    for (int j = 0; j < LL; j++)
      for (int i = 0; i < cur_n; i++) begin
        int p;
        p = cur_e[i] - LOFF[j];
        if (p < 0) p = p + P;
        exp_pos[k] = p;
        k++;
        exp_syn[p / NB] = exp_syn[p / NB] ^ (1 << (p % NB));
      end
  endtask

  task automatic go(input bit restart, input string wtag);
    int cyc;
    wr_cnt = 0; mon_k = 0; mon_en = 1;
    err_count = 3'(cur_n);
    @(posedge clk); #1 start = 1;
    cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      #1;
      if (cyc == 1) start = 0;
      if (restart && cyc == 4) start = 1;
      if (restart && cyc == 5) start = 0;
      @(negedge clk);
      if (cyc == 2 && cur_n > 0) chk(busy == 1, "R8 busy", int'(busy), 1);
      if (done || cyc > 200) break;
    end
    chk(cyc == 3 * cur_n * LL + 1, "R9 cycles", cyc, 3 * cur_n * LL + 1);
    @(negedge clk);
    chk(done == 0, "R8 done pulse", int'(done), 0);
    chk(busy == 0, "R8 idle after done", int'(busy), 0);
    chk(mon_k == cur_n * LL, "R4 beat count", mon_k, cur_n * LL);
    chk(wr_cnt == cur_n * LL, "R5 write count", wr_cnt, cur_n * LL);
    for (int w = 0; w < WORDS; w++)
      chk(int'(syn_mem[w]) == exp_syn[w], wtag, int'(syn_mem[w]), exp_syn[w]);
    mon_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      err_mem[i] = '0;
      lpos_mem[i] = (i < LL) ? 6'(LOFF[i]) : '0;
    end
    for (int w = 0; w < WORDS; w++) syn_mem[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
    chk(!syn_rd_en && !syn_wr_en && !pos_valid, "R1 strobes",
        int'({syn_rd_en, syn_wr_en, pos_valid}), 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // table walk: R2/R3/R4/R5 across patterns, R6 on repeated positions
    for (int c = 0; c < 5; c++) begin
      cur_n = int'(CASES[c][26:24]);
      for (int i = 0; i < 4; i++) cur_e[i] = int'(CASES[c][i*6 +: 6]);
      prep(c + 1);
      go(0, (c == 2 || c == 4) ? "R6 cancel/back-to-back word" : "R3 word");
    end

    // R7 empty error list
    cur_n = 0;
    prep(11);
    go(0, "R7 untouched word");

    // R8 start while busy is ignored
    cur_n = 4;
    cur_e[0] = 30; cur_e[1] = 30; cur_e[2] = 12; cur_e[3] = 19;
    prep(13);
    go(1, "R8 word with restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule